// File: doc/BRIEF.md
# Converter Operating Mode Sequencer

This block is the supervisory state machine of a switching power controller. It takes digital comparator flags (supply level against three thresholds, feedback pins in range, optocoupler-pin disable, low brownout current, overload, overcurrent and input surge). From these it decides which of five operating modes the controller is in: start-up, ramp-up, active, stop or low-consumption. It drives the switching enable for the gate path and selects the current source that charges the supply from the high-voltage input.

Timed protections (over-power and brownout) must see their fault flag for a persistence interval before they act. They then shut the converter down into low-consumption mode for a restart delay, after which the controller restarts by itself. No fault latches. After the very first power-on, a ramp-up window blanks the timed protections. A restart that comes out of low-consumption goes straight to active mode. All times are parameters counted in clock ticks.

Top module: `mode_sequencer`

## Requirements
- R1: Exactly one mode bit is set at all times, encoded as bit0 start-up, bit1 ramp-up, bit2 active, bit3 stop and bit4 low-consumption. A synchronous reset forces start-up with switching disabled.
- R2: Start-up is left only on a clock edge where the supply is above the turn-on threshold and both feedback flags report in-range. Otherwise it stays in start-up.
- R3: Leaving start-up after a first power-on goes to ramp-up. Leaving it after low-consumption goes directly to active.
- R4: Ramp-up lasts T_SS cycles and then passes to active. During ramp-up, overload and brownout flags have no effect.
- R5: In active mode, an overload flag held for T_OPP consecutive cycles moves the controller to low-consumption. It stays there for T_REC cycles and then returns to start-up, provided the optocoupler disable is not asserted.
- R6: In active mode, a brownout flag held for T_BO consecutive cycles moves the controller to low-consumption with the same T_REC restart delay.
- R7: A persistence count restarts from zero whenever its fault flag drops before expiry.
- R8: The overcurrent flag clears the switching enable in the same cycle. It moves ramp-up or active to stop for T_OCP cycles, after which the controller resumes the mode it left.
- R9: The surge flag clears the switching enable in the same cycle in every mode. It moves ramp-up or active to stop, and the controller resumes on the edge after the flag clears.
- R10: In stop mode, an asserted optocoupler disable or a supply below the restart threshold moves the controller to low-consumption. In low-consumption, an asserted optocoupler disable holds the mode.
- R11: In ramp-up or active, an asserted optocoupler disable or a supply below the restart threshold moves the controller to low-consumption with no restart delay.
- R12: The charge select is 00 (off), 01 (small) or 10 (large). In start-up it is 01 below the restart threshold, 10 between the restart and turn-on thresholds, and 00 at or above turn-on. In low-consumption it turns to 10 when the supply drops below restart and stays 10 until the supply reaches turn-on. It is 00 in ramp-up, active and stop.
- R13: A supply below the reset threshold forces start-up from any mode and marks the next exit as a first power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sup_above_reset_i | input | 1 | Supply above the logic reset threshold |
| sup_above_restart_i | input | 1 | Supply above the restart threshold |
| sup_above_on_i | input | 1 | Supply above the turn-on threshold |
| psr_fb_ok_i | input | 1 | Primary-side feedback pin within operating range |
| opto_fb_ok_i | input | 1 | Optocoupler feedback pin within operating range |
| opto_disable_i | input | 1 | Optocoupler pin pulled below its disable threshold |
| bo_low_i | input | 1 | Sensed brownout current below its level |
| overload_i | input | 1 | Feedback clamped above the overload threshold |
| ocp_i | input | 1 | Second-level overcurrent event |
| surge_i | input | 1 | Input voltage above the surge threshold |
| mode_o | output | 5 | One-hot operating mode |
| sw_en_o | output | 1 | Switching enable for the gate path |
| chg_sel_o | output | 2 | Start-up charge source select |

## Verification
Mode changes are registered. A flag present at one rising edge shows on the mode output right after that edge. A persistence or hold interval of T cycles changes the mode after exactly the T-th edge. The switching enable and the charge select follow their inputs in the same cycle, except for the low-consumption hysteresis, which takes effect one edge after the supply crosses a threshold. The bench changes inputs on falling edges and reads outputs on falling edges. For each timed case it checks the mode both one edge before the expected change and at the expected change.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [4:0] {
        M_START = 5'b00001,
        M_RAMP  = 5'b00010,
        M_ACT   = 5'b00100,
        M_STOP  = 5'b01000,
        M_LOWC  = 5'b10000
    } mode_t;

    typedef enum logic [1:0] {
        CHG_OFF   = 2'b00,
        CHG_SMALL = 2'b01,
        CHG_LARGE = 2'b10
    } chg_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fault_timer.sv
module fault_timer #(
    parameter int LIMIT = 8,
    parameter int W     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (cnt_q != LAST)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q == LAST);

    // persistence never survives a dropped flag
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !expired_o);

endmodule

// File: rtl/charge_ctrl.sv
module charge_ctrl
    import seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode_i,
    input  logic  above_restart_i,
    input  logic  above_on_i,
    output chg_t  chg_o
);
    logic hyst_d, hyst_q;
    logic refill;

    assign refill = !above_restart_i || (hyst_q && !above_on_i);

    always_comb begin
        hyst_d = refill;
    end

    always_ff @(posedge clk) begin
        if (rst) hyst_q <= 1'b0;
        else     hyst_q <= hyst_d;
    end

    always_comb begin
        chg_o = CHG_OFF;
        case (mode_i)
            M_START: begin
                if (!above_restart_i)  chg_o = CHG_SMALL;
                else if (!above_on_i)  chg_o = CHG_LARGE;
            end
            M_LOWC: if (refill) chg_o = CHG_LARGE;
            default: chg_o = CHG_OFF;
        endcase
    end

    p_lowc_refill_r12: assert property (@(posedge clk) disable iff (rst)
        (mode_i == M_LOWC && !above_restart_i) |-> (chg_o == CHG_LARGE));

endmodule

// File: rtl/mode_sequencer.sv
module mode_sequencer
    import seq_pkg::*;
#(
    parameter int T_SS  = 850000,
    parameter int T_OPP = 100000,
    parameter int T_BO  = 100000,
    parameter int T_OCP = 1000,
    parameter int T_REC = 2500000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sup_above_reset_i,
    input  logic       sup_above_restart_i,
    input  logic       sup_above_on_i,
    input  logic       psr_fb_ok_i,
    input  logic       opto_fb_ok_i,
    input  logic       opto_disable_i,
    input  logic       bo_low_i,
    input  logic       overload_i,
    input  logic       ocp_i,
    input  logic       surge_i,
    output logic [4:0] mode_o,
    output logic       sw_en_o,
    output logic [1:0] chg_sel_o
);
    localparam int CMAX = imax(imax(T_SS, T_OCP), T_REC);
    localparam int CW   = $clog2(CMAX + 1);
    localparam int FMAX = imax(T_OPP, T_BO);
    localparam int FW   = $clog2(FMAX + 1);
    localparam int NF   = 2;
    localparam int FLIM [NF] = '{T_OPP, T_BO};

    localparam logic [CW-1:0] LD_SS  = CW'(T_SS - 1);
    localparam logic [CW-1:0] LD_OCP = CW'(T_OCP - 1);
    localparam logic [CW-1:0] LD_REC = CW'(T_REC - 1);

    typedef struct packed {
        mode_t         mode;
        logic          first;
        logic          back_ramp;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    logic [NF-1:0] flt_run, flt_exp;
    logic          any_exp;
    logic          fb_ok, supply_lost, go_low;
    chg_t          chg;

    // timed protections: index 0 over-power, index 1 brownout
    assign flt_run = {bo_low_i, overload_i} & {NF{st_q.mode == M_ACT}};

    for (genvar g = 0; g < NF; g++) begin : g_flt
        fault_timer #(.LIMIT(FLIM[g]), .W(FW)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .run_i    (flt_run[g]),
            .expired_o(flt_exp[g])
        );
    end

    assign any_exp     = |flt_exp;
    assign fb_ok       = psr_fb_ok_i && opto_fb_ok_i;
    assign supply_lost = !sup_above_restart_i;
    assign go_low      = supply_lost || opto_disable_i;

    always_comb begin
        st_d = st_q;
        case (st_q.mode)
            M_START: begin
                if (sup_above_on_i && fb_ok) begin
                    if (st_q.first) begin
                        st_d.mode  = M_RAMP;
                        st_d.first = 1'b0;
                        st_d.cnt   = LD_SS;
                    end else begin
                        st_d.mode  = M_ACT;
                    end
                end
            end
            M_RAMP: begin
                if (surge_i) begin
                    st_d.mode      = M_STOP;
                    st_d.cnt       = '0;
                    st_d.back_ramp = 1'b1;
                end else if (ocp_i) begin
                    st_d.mode      = M_STOP;
                    st_d.cnt       = LD_OCP;
                    st_d.back_ramp = 1'b1;
                end else if (go_low) begin
                    st_d.mode      = M_LOWC;
                    st_d.cnt       = '0;
                end else if (st_q.cnt == '0) begin
                    st_d.mode      = M_ACT;
                end else begin
                    st_d.cnt       = st_q.cnt - CW'(1);
                end
            end
            M_ACT: begin
                if (surge_i) begin
                    st_d.mode      = M_STOP;
                    st_d.cnt       = '0;
                    st_d.back_ramp = 1'b0;
                end else if (ocp_i) begin
                    st_d.mode      = M_STOP;
                    st_d.cnt       = LD_OCP;
                    st_d.back_ramp = 1'b0;
                end else if (any_exp) begin
                    st_d.mode      = M_LOWC;
                    st_d.cnt       = LD_REC;
                end else if (go_low) begin
                    st_d.mode      = M_LOWC;
                    st_d.cnt       = '0;
                end
            end
            M_STOP: begin
                if (ocp_i) begin
                    st_d.cnt  = LD_OCP;
                end else if (go_low) begin
                    st_d.mode = M_LOWC;
                    st_d.cnt  = '0;
                end else if (st_q.cnt != '0) begin
                    st_d.cnt  = st_q.cnt - CW'(1);
                end else if (!surge_i) begin
                    if (st_q.back_ramp) begin
                        st_d.mode = M_RAMP;
                        st_d.cnt  = LD_SS;
                    end else begin
                        st_d.mode = M_ACT;
                    end
                end
            end
            M_LOWC: begin
                if (st_q.cnt != '0)
                    st_d.cnt  = st_q.cnt - CW'(1);
                else if (!opto_disable_i)
                    st_d.mode = M_START;
            end
            default: st_d.mode = M_START;
        endcase

        if (!sup_above_reset_i) begin
            st_d.mode      = M_START;
            st_d.first     = 1'b1;
            st_d.back_ramp = 1'b0;
            st_d.cnt       = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode      <= M_START;
            st_q.first     <= 1'b1;
            st_q.back_ramp <= 1'b0;
            st_q.cnt       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    charge_ctrl u_chg (
        .clk            (clk),
        .rst            (rst),
        .mode_i         (st_q.mode),
        .above_restart_i(sup_above_restart_i),
        .above_on_i     (sup_above_on_i),
        .chg_o          (chg)
    );

    assign mode_o    = st_q.mode;
    assign chg_sel_o = chg;
    assign sw_en_o   = (st_q.mode == M_RAMP || st_q.mode == M_ACT) && !surge_i && !ocp_i;

    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(mode_o) == 1);

    p_start_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_START && !(sup_above_on_i && fb_ok)) |=> (st_q.mode == M_START));

    p_no_ramp_reentry_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_START && !st_q.first && sup_above_reset_i) |=> (st_q.mode != M_RAMP));

    p_ramp_blank_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_RAMP) |-> !any_exp);

    p_surge_stop_r9: assert property (@(posedge clk) disable iff (rst)
        ((st_q.mode == M_ACT || st_q.mode == M_RAMP) && surge_i && sup_above_reset_i)
        |=> (st_q.mode == M_STOP));

    p_lowc_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_LOWC && opto_disable_i && sup_above_reset_i) |=> (st_q.mode == M_LOWC));

    p_chg_off_r12: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_ACT || st_q.mode == M_RAMP || st_q.mode == M_STOP)
        |-> (chg_sel_o == 2'b00));

endmodule

// File: tb/sim_mode_sequencer.sv
module sim_mode_sequencer;

    localparam int PERIOD = 10;
    localparam int SS  = 20;
    localparam int OPP = 8;
    localparam int BO  = 12;
    localparam int OCP = 5;
    localparam int REC = 15;

    localparam logic [4:0] MS = 5'b00001, MR = 5'b00010, MA = 5'b00100,
                           MT = 5'b01000, ML = 5'b10000;

    logic clk = 1'b0;
    logic rst;
    logic rs_ok, rest, on, fb1, fb2, odis, bo, ovl, ocp, surge;
    logic [4:0] mode;
    logic       sw;
    logic [1:0] chg;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    mode_sequencer #(.T_SS(SS), .T_OPP(OPP), .T_BO(BO), .T_OCP(OCP), .T_REC(REC)) u0 (
        .clk(clk), .rst(rst),
        .sup_above_reset_i(rs_ok), .sup_above_restart_i(rest), .sup_above_on_i(on),
        .psr_fb_ok_i(fb1), .opto_fb_ok_i(fb2), .opto_disable_i(odis),
        .bo_low_i(bo), .overload_i(ovl), .ocp_i(ocp), .surge_i(surge),
        .mode_o(mode), .sw_en_o(sw), .chg_sel_o(chg)
    );

    // startup-mode vectors: {restart, on, fb1, fb2, expected charge select}
    localparam int NV = 6;
    localparam logic [5:0] VEC [NV] = '{
        6'b0011_01, 6'b1011_10, 6'b1101_00,
        6'b1110_00, 6'b1100_00, 6'b0000_01
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; rs_ok = 1; rest = 0; on = 0; fb1 = 0; fb2 = 0;
        odis = 0; bo = 0; ovl = 0; ocp = 0; surge = 0;
        step(2);
        rst = 0;
        step(1);
        chk("R1 reset mode", mode, MS);
        chk("R1 reset sw_en", {4'b0, sw}, 5'd0);
        chk("R12 reset charge small", {3'b0, chg}, 5'd1);

        for (int i = 0; i < NV; i++) begin
            {rest, on, fb1, fb2} = VEC[i][5:2];
            step(1);
            chk("R2 start-up held", mode, MS);
            chk("R12 start-up charge", {3'b0, chg}, {3'b0, VEC[i][1:0]});
        end

        rest = 1; on = 1; fb1 = 1; fb2 = 1;
        step(1);
        chk("R3 first power-on to ramp", mode, MR);
        chk("R12 ramp charge off", {3'b0, chg}, 5'd0);
        ovl = 1; bo = 1;
        step(SS - 1);
        chk("R4 ramp still held, faults blanked", mode, MR);
        step(1);
        chk("R4 ramp to active", mode, MA);
        chk("R4 sw_en in active", {4'b0, sw}, 5'd1);
        ovl = 0; bo = 0;

        ovl = 1; step(OPP - 1); ovl = 0; step(1);
        ovl = 1; step(OPP - 1);
        chk("R7 count restarted after drop", mode, MA);
        step(1);
        chk("R5 over-power to low-consumption", mode, ML);
        chk("R5 sw_en off", {4'b0, sw}, 5'd0);
        ovl = 0;

        on = 0;
        step(1);
        chk("R12 lowc between thresholds off", {3'b0, chg}, 5'd0);
        rest = 0;
        step(1);
        chk("R12 lowc refill below restart", {3'b0, chg}, 5'd2);
        rest = 1;
        step(1);
        chk("R12 lowc hysteresis holds refill", {3'b0, chg}, 5'd2);
        on = 1;
        #1;
        chk("R12 lowc refill stops at turn-on", {3'b0, chg}, 5'd0);
        step(REC - 1 - 3);
        chk("R5 restart delay not elapsed", mode, ML);
        step(1);
        chk("R5 restart to start-up", mode, MS);
        step(1);
        chk("R3 re-entry skips ramp", mode, MA);

        bo = 1;
        step(BO - 1);
        chk("R6 brownout not yet", mode, MA);
        step(1);
        chk("R6 brownout to low-consumption", mode, ML);
        bo = 0; odis = 1;
        step(REC + 3);
        chk("R10 disable holds low-consumption", mode, ML);
        odis = 0;
        step(1);
        chk("R5 restart after disable released", mode, MS);
        step(1);
        chk("R3 back to active", mode, MA);

        ocp = 1;
        #1;
        chk("R8 sw_en cut at once", {4'b0, sw}, 5'd0);
        step(1);
        chk("R8 overcurrent to stop", mode, MT);
        ocp = 0;
        step(OCP - 1);
        chk("R8 stop hold", mode, MT);
        step(1);
        chk("R8 resume active", mode, MA);

        surge = 1;
        #1;
        chk("R9 sw_en cut at once", {4'b0, sw}, 5'd0);
        step(1);
        chk("R9 surge to stop", mode, MT);
        step(10);
        chk("R9 stop while surge", mode, MT);
        surge = 0;
        step(1);
        chk("R9 resume after surge", mode, MA);

        ocp = 1; step(1); ocp = 0;
        odis = 1;
        step(1);
        chk("R10 stop to low-consumption", mode, ML);
        odis = 0;
        step(2);
        chk("R10 recovered to active", mode, MA);

        rest = 0;
        step(1);
        chk("R11 supply low to low-consumption", mode, ML);
        chk("R12 lowc refill", {3'b0, chg}, 5'd2);
        rest = 1;
        step(2);
        chk("R11 recovered to active", mode, MA);
        odis = 1;
        step(1);
        chk("R11 disable to low-consumption", mode, ML);
        odis = 0;
        step(2);
        chk("R11 recovered again", mode, MA);

        rs_ok = 0;
        step(1);
        chk("R13 reset threshold lost", mode, MS);
        rs_ok = 1;
        step(1);
        chk("R13 ramp after new power-on", mode, MR);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule